// File: doc/BRIEF.md
# PWM Time Base with Event-Driven Output Actions

This block generates two pulse-width-modulated outputs from one shared counter. A prescaler slows the system clock into counter ticks. On each tick the counter steps in one of three patterns: rising, falling, or rising then falling (triangle). The counter runs against a programmable period. Two compare values are checked against the counter. A compare match is tagged with the direction the counter was moving. The matches, together with "counter at zero" and "counter at period", give six events per tick.

Each output has its own 16-bit action word. The word holds a 2-bit action for each of the six events: keep, drive low, drive high, or flip. Between events the output holds its level. This lets edge-aligned, centre-aligned and complementary waveforms all come from the same hardware.

The period and both compares can be written directly or through holding copies. Holding copies are committed at the zero point of the counter, so a new duty cycle never lands mid-cycle.

Top module: `pwm_aq_top`

## Requirements
- R1: After reset the counter is 0, the direction flag shows up (1), and both outputs are 0.
- R2: A counter tick occurs once every (pre_a+1)*(pre_b+1) clock cycles. With both codes at 0, there is a tick on every clock.
- R3: With `mode` = 0 (up), the counter runs 0, 1, …, P and then returns to 0, so one cycle lasts P+1 ticks. The direction flag stays 1.
- R4: With `mode` = 1 (down), the counter runs P, P-1, …, 0 and then reloads P, so one cycle lasts P+1 ticks. The direction flag is 0.
- R5: With `mode` = 2 (up-down), the counter rises from 0 to P and falls back to 0, so one cycle lasts 2P ticks. The direction flag is still 1 while the counter shows P, and is 0 from the next value on.
- R6: Each action word assigns a 2-bit field to each event. Bits 1:0 hold the zero event, 3:2 the period event, 5:4 compare A rising, 7:6 compare A falling, 9:8 compare B rising, and 11:10 compare B falling. Bits 15:12 are unused. Code 00 keeps the output, 01 drives 0, 10 drives 1, and 11 inverts. With no event, the output holds.
- R7: A compare value larger than the active period never produces an event, so a 0% or 100% duty cycle can be held.
- R8: When several events on one tick have non-keep actions, only one is applied. The order from highest to lowest is period, zero, compare B, compare A.
- R9: In up-down mode, compare events are suppressed on the ticks where the counter is at zero or at the period. Only the zero or period event fires there.
- R10: When `shadow_en` = 1, a write changes only the holding copy, and the active value takes it on the tick where the counter is at 0. When `shadow_en` = 0, the write takes effect in the next cycle.
- R11: With `mode` = 3 (hold), the prescaler and counter stop, and the counter and both outputs keep their values.
- R12: A compare match raises the rising event only while the direction flag is 1, and the falling event only while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 up, 1 down, 2 up-down, 3 hold |
| pre_a | input | 3 | First prescale code, factor = code+1 |
| pre_b | input | 3 | Second prescale code, factor = code+1 |
| shadow_en | input | 1 | 1: writes go through holding copies committed at zero |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | 16 | Period write value |
| cmpa_wr | input | 1 | Compare A write strobe |
| cmpa_wdata | input | 16 | Compare A write value |
| cmpb_wr | input | 1 | Compare B write strobe |
| cmpb_wdata | input | 16 | Compare B write value |
| act_word_a | input | 16 | Action word for output A |
| act_word_b | input | 16 | Action word for output B |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| cnt | output | 16 | Current counter value |
| cnt_up | output | 1 | Direction flag, 1 while counting up |

## Verification
Events are evaluated from the counter value held during a tick. The counter and the outputs both change on the clock edge that ends that tick. So an output change for count value X appears in the same cycle that the counter shows the next value. A direct write shows up in the active value one edge after the strobe.

The vector table avoids phase dependence: after a warm-up, the bench counts the high cycles of each output over two full counter cycles, sampling on falling edges. The directed tests follow the counter cycle by cycle:
- the counter value three edges after a mode change;
- the direction flag at and just after the peak;
- the largest value seen before each wrap, for the holding-copy checks;
- the gap between counter changes under prescale.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  localparam int ACT_WORD_W = 16;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    MODE_UP   = 2'd0,
    MODE_DOWN = 2'd1,
    MODE_UPDN = 2'd2,
    MODE_HOLD = 2'd3
  } cnt_mode_e;

  typedef struct packed {
    logic prd;
    logic zero;
    logic cb_up;
    logic cb_dn;
    logic ca_up;
    logic ca_dn;
  } pwm_ev_t;

  // field slot of each event inside an action word (2 bits per slot)
  localparam int SLOT_ZERO = 0;
  localparam int SLOT_PRD  = 1;
  localparam int SLOT_CAU  = 2;
  localparam int SLOT_CAD  = 3;
  localparam int SLOT_CBU  = 4;
  localparam int SLOT_CBD  = 5;

  function automatic act_e act_field(input logic [ACT_WORD_W-1:0] word, input int slot);
    return act_e'(word[2*slot +: 2]);
  endfunction

  // later checks override earlier ones: lowest priority first
  function automatic act_e pick_action(input pwm_ev_t ev, input logic [ACT_WORD_W-1:0] word);
    act_e sel;
    sel = ACT_KEEP;
    if (ev.ca_dn && act_field(word, SLOT_CAD) != ACT_KEEP) sel = act_field(word, SLOT_CAD);
    if (ev.ca_up && act_field(word, SLOT_CAU) != ACT_KEEP) sel = act_field(word, SLOT_CAU);
    if (ev.cb_dn && act_field(word, SLOT_CBD) != ACT_KEEP) sel = act_field(word, SLOT_CBD);
    if (ev.cb_up && act_field(word, SLOT_CBU) != ACT_KEEP) sel = act_field(word, SLOT_CBU);
    if (ev.zero  && act_field(word, SLOT_ZERO) != ACT_KEEP) sel = act_field(word, SLOT_ZERO);
    if (ev.prd   && act_field(word, SLOT_PRD) != ACT_KEEP) sel = act_field(word, SLOT_PRD);
    return sel;
  endfunction

  function automatic logic apply_action(input logic cur, input act_e a);
    case (a)
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_FLIP: return ~cur;
      default:  return cur;
    endcase
  endfunction

  function automatic int unsigned tick_span(input int unsigned code_a, input int unsigned code_b);
    return (code_a + 1) * (code_b + 1);
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_aq_pkg::*;
#(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_a,
  input  logic [PRE_W-1:0] pre_b,
  output logic             tick
);

  localparam int PC_W = 2 * PRE_W;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] limit;

  assign limit = PC_W'(tick_span(32'(pre_a), 32'(pre_b)) - 1);
  assign tick  = run && (pc_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)           pc_q <= '0;
    else if (!run || tick) pc_q <= '0;
    else                  pc_q <= pc_q + 1'b1;
  end

  // R2: a divided tick is never followed directly by another one
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && limit != '0) |=> (!tick || limit == '0));

  // R11: no ticks while stopped
  p_no_tick_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

endmodule

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shadow_en,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] active
);

  logic [W-1:0] hold_q;
  logic [W-1:0] active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= '0;
      active_q <= '0;
    end else begin
      if (wr) hold_q <= wdata;
      if (!shadow_en && wr)     active_q <= wdata;
      else if (shadow_en && load) active_q <= hold_q;
    end
  end

  assign active = active_q;

  // R10: with holding copies on, the active value moves only at a zero load
  p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_en && !load) |=> $stable(active_q));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_up,
  output logic             turn,
  output pwm_ev_t          ev
);

  cnt_mode_e       m;
  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;
  logic             at_zero;
  logic             at_prd;
  logic             hit_a;
  logic             hit_b;

  assign m       = cnt_mode_e'(mode);
  assign at_zero = (cnt_q == '0);
  assign at_prd  = (cnt_q == per);
  assign turn    = (m == MODE_UPDN) && (at_zero || at_prd);
  assign hit_a   = tick && !turn && (cmp_a <= per) && (cnt_q == cmp_a);
  assign hit_b   = tick && !turn && (cmp_b <= per) && (cnt_q == cmp_b);

  always_comb begin
    ev       = '0;
    ev.zero  = tick && at_zero;
    ev.prd   = tick && at_prd;
    ev.ca_up = hit_a && dir_q;
    ev.ca_dn = hit_a && !dir_q;
    ev.cb_up = hit_b && dir_q;
    ev.cb_dn = hit_b && !dir_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (tick) begin
      case (m)
        MODE_UP: begin
          dir_q <= 1'b1;
          cnt_q <= (cnt_q >= per) ? '0 : cnt_q + 1'b1;
        end
        MODE_DOWN: begin
          dir_q <= 1'b0;
          cnt_q <= (at_zero || cnt_q > per) ? per : cnt_q - 1'b1;
        end
        MODE_UPDN: begin
          if (dir_q) begin
            if (cnt_q >= per) begin
              dir_q <= 1'b0;
              cnt_q <= (per == '0) ? '0 : per - 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end else begin
            if (at_zero) begin
              dir_q <= 1'b1;
              cnt_q <= (per == '0) ? '0 : CNT_W'(1);
            end else if (cnt_q > per) begin
              cnt_q <= per;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign cnt    = cnt_q;
  assign dir_up = dir_q;

  // R3: in up mode the counter wraps to zero after reaching the period
  p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && m == MODE_UP && cnt_q >= per) |=> cnt_q == '0);

  // R5: the direction turns down right after the peak
  p_updn_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && m == MODE_UPDN && dir_q && cnt_q >= per) |=> !dir_q);

  // R11: a stopped counter keeps its value
  p_hold_cnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m == MODE_HOLD) |=> $stable(cnt_q));

  // R7: no compare event from a value past the period
  p_cmp_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.ca_up || ev.ca_dn) |-> (cmp_a <= per));

  // R9: turning points carry no compare event
  p_turn_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
    turn |-> !(ev.ca_up || ev.ca_dn || ev.cb_up || ev.cb_dn));

endmodule

// File: rtl/pwm_action_out.sv
module pwm_action_out
  import pwm_aq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  pwm_ev_t               ev,
  input  logic [ACT_WORD_W-1:0] word,
  output logic                  out
);

  act_e act_sel;
  logic out_q;

  assign act_sel = pick_action(ev, word);

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= apply_action(out_q, act_sel);
  end

  assign out = out_q;

  // R6: without an event the output holds
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == '0) |=> $stable(out_q));

  // R8: a period event asking for high always wins
  p_prd_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.prd && word[3:2] == 2'b10) |=> out_q);

endmodule

// File: rtl/pwm_aq_top.sv
module pwm_aq_top
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [PRE_W-1:0] pre_a,
  input  logic [PRE_W-1:0] pre_b,
  input  logic             shadow_en,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  input  logic             cmpa_wr,
  input  logic [CNT_W-1:0] cmpa_wdata,
  input  logic             cmpb_wr,
  input  logic [CNT_W-1:0] cmpb_wdata,
  input  logic [15:0]      act_word_a,
  input  logic [15:0]      act_word_b,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_up
);

  localparam int NUM_REG = 3;
  localparam int NUM_OUT = 2;

  logic             run;
  logic             tick;
  logic             zero_load;
  logic             turn;
  pwm_ev_t          ev;
  logic [CNT_W-1:0] cnt_w;
  logic             dir_w;

  logic             reg_wr    [NUM_REG];
  logic [CNT_W-1:0] reg_wdata [NUM_REG];
  logic [CNT_W-1:0] reg_act   [NUM_REG];
  logic [15:0]      words     [NUM_OUT];
  logic             outs      [NUM_OUT];

  assign run       = (cnt_mode_e'(mode) != MODE_HOLD);
  assign zero_load = tick && (cnt_w == '0);

  assign reg_wr[0]    = per_wr;
  assign reg_wdata[0] = per_wdata;
  assign reg_wr[1]    = cmpa_wr;
  assign reg_wdata[1] = cmpa_wdata;
  assign reg_wr[2]    = cmpb_wr;
  assign reg_wdata[2] = cmpb_wdata;
  assign words[0]     = act_word_a;
  assign words[1]     = act_word_b;

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .pre_a (pre_a),
    .pre_b (pre_b),
    .tick  (tick)
  );

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    pwm_shadow_reg #(.W(CNT_W)) u_sh (
      .clk       (clk),
      .rst_n     (rst_n),
      .shadow_en (shadow_en),
      .wr        (reg_wr[r]),
      .wdata     (reg_wdata[r]),
      .load      (zero_load),
      .active    (reg_act[r])
    );
  end

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .mode   (mode),
    .per    (reg_act[0]),
    .cmp_a  (reg_act[1]),
    .cmp_b  (reg_act[2]),
    .cnt    (cnt_w),
    .dir_up (dir_w),
    .turn   (turn),
    .ev     (ev)
  );

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    pwm_action_out u_act (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev),
      .word  (words[o]),
      .out   (outs[o])
    );
  end

  assign pwm_a  = outs[0];
  assign pwm_b  = outs[1];
  assign cnt    = cnt_w;
  assign cnt_up = dir_w;

  // R12: rising-tagged compare events only while counting up
  p_dir_tag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.ca_up || ev.cb_up) |-> cnt_up);

  // R10: a direct write reaches the active period one edge later
  p_direct_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!shadow_en && per_wr) |=> reg_act[0] == $past(per_wdata));

endmodule

// File: tb/pwm_aq_top_bench.sv
`timescale 1ns/1ps
module pwm_aq_top_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [2:0]  pre_a, pre_b;
  logic        shadow_en;
  logic        per_wr, cmpa_wr, cmpb_wr;
  logic [15:0] per_wdata, cmpa_wdata, cmpb_wdata;
  logic [15:0] act_word_a, act_word_b;
  logic        pwm_a, pwm_b, cnt_up;
  logic [15:0] cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pwm_aq_top u_pwm_aq_top (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pre_a(pre_a), .pre_b(pre_b),
    .shadow_en(shadow_en), .per_wr(per_wr), .per_wdata(per_wdata),
    .cmpa_wr(cmpa_wr), .cmpa_wdata(cmpa_wdata), .cmpb_wr(cmpb_wr),
    .cmpb_wdata(cmpb_wdata), .act_word_a(act_word_a), .act_word_b(act_word_b),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .cnt(cnt), .cnt_up(cnt_up)
  );

  typedef struct packed {
    logic [1:0]  md;
    logic [15:0] per;
    logic [15:0] ca;
    logic [15:0] cb;
    logic [15:0] wa;
    logic [15:0] wb;
    logic [15:0] win;
    logic [15:0] hi_a;
    logic [15:0] hi_b;
  } vec_t;

  localparam int NV = 8;
  // window = two counter cycles; expected = high cycles of each output in it
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'd9, 16'd4,  16'd7, 16'h0012, 16'h0102, 16'd20, 16'd8,  16'd14}, // R3 R6 edge aligned
    '{2'd0, 16'd9, 16'd12, 16'd3, 16'h0012, 16'h0201, 16'd20, 16'd20, 16'd14}, // R7 compare past period
    '{2'd1, 16'd9, 16'd3,  16'd6, 16'h0048, 16'h0402, 16'd20, 16'd12, 16'd8},  // R4 R12 falling count
    '{2'd2, 16'd8, 16'd3,  16'd0, 16'h0060, 16'h0006, 16'd32, 16'd20, 16'd16}, // R5 R12 centre aligned
    '{2'd0, 16'd9, 16'd0,  16'd9, 16'h0012, 16'h0204, 16'd20, 16'd20, 16'd0},  // R8 zero/period over compare
    '{2'd0, 16'd9, 16'd5,  16'd5, 16'h0120, 16'h0210, 16'd20, 16'd0,  16'd20}, // R8 B over A
    '{2'd2, 16'd8, 16'd8,  16'd0, 16'h0060, 16'h0900, 16'd32, 16'd0,  16'd0},  // R9 turning points
    '{2'd0, 16'd4, 16'd0,  16'd0, 16'h0003, 16'h000C, 16'd10, 16'd5,  16'd5}   // R6 invert code
  };

  function automatic string vec_req(input int i);
    case (i)
      0: return "R3/R6";
      1: return "R7";
      2: return "R4/R12";
      3: return "R5/R12";
      4, 5: return "R8";
      6: return "R9";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mode = 2'd3; pre_a = '0; pre_b = '0; shadow_en = 1'b0;
    per_wr = 1'b0; cmpa_wr = 1'b0; cmpb_wr = 1'b0;
    per_wdata = '0; cmpa_wdata = '0; cmpb_wdata = '0;
    act_word_a = '0; act_word_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // called at a falling edge; strobe is held for one cycle
  task automatic write_reg(input int which, input logic [15:0] v);
    case (which)
      0: begin per_wr = 1'b1;  per_wdata = v;  end
      1: begin cmpa_wr = 1'b1; cmpa_wdata = v; end
      default: begin cmpb_wr = 1'b1; cmpb_wdata = v; end
    endcase
    @(negedge clk);
    per_wr = 1'b0; cmpa_wr = 1'b0; cmpb_wr = 1'b0;
  endtask

  // largest counter value seen until the counter drops
  task automatic max_until_wrap(output int mx);
    int prev;
    prev = int'(cnt);
    mx = prev;
    forever begin
      @(negedge clk);
      if (int'(cnt) < prev) break;
      prev = int'(cnt);
      if (prev > mx) mx = prev;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int mx, gap, c0, ha, hb;
    logic a0;
    do_reset();
    // R1 reset state
    check(cnt == 16'd0, "R1 cnt", int'(cnt), 0);
    check(cnt_up == 1'b1, "R1 dir", int'(cnt_up), 1);
    check(pwm_a == 1'b0, "R1 pwm_a", int'(pwm_a), 0);
    check(pwm_b == 1'b0, "R1 pwm_b", int'(pwm_b), 0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      write_reg(0, VECS[i].per);
      write_reg(1, VECS[i].ca);
      write_reg(2, VECS[i].cb);
      act_word_a = VECS[i].wa;
      act_word_b = VECS[i].wb;
      mode = VECS[i].md;
      repeat (3 * int'(VECS[i].win)) @(negedge clk);
      ha = 0; hb = 0;
      for (int k = 0; k < int'(VECS[i].win); k++) begin
        @(negedge clk);
        if (pwm_a) ha++;
        if (pwm_b) hb++;
      end
      check(ha == int'(VECS[i].hi_a), {vec_req(i), " high A"}, ha, int'(VECS[i].hi_a));
      check(hb == int'(VECS[i].hi_b), {vec_req(i), " high B"}, hb, int'(VECS[i].hi_b));
    end

    // R2 prescale: factors 2 and 3 give a tick every 6 clocks
    do_reset();
    write_reg(0, 16'd99);
    pre_a = 3'd1; pre_b = 3'd2; mode = 2'd0;
    c0 = int'(cnt);
    do @(negedge clk); while (int'(cnt) == c0);
    c0 = int'(cnt); gap = 0;
    do begin @(negedge clk); gap++; end while (int'(cnt) == c0);
    check(gap == 6, "R2 tick gap", gap, 6);

    // R4 falling count: three edges after start the counter shows 7
    do_reset();
    write_reg(0, 16'd9);
    mode = 2'd1;
    repeat (3) @(negedge clk);
    check(cnt == 16'd7, "R4 cnt", int'(cnt), 7);
    check(cnt_up == 1'b0, "R4 dir", int'(cnt_up), 0);

    // R5 direction flag around the peak
    do_reset();
    write_reg(0, 16'd8);
    mode = 2'd2;
    do @(negedge clk); while (cnt != 16'd8);
    check(cnt_up == 1'b1, "R5 dir at peak", int'(cnt_up), 1);
    @(negedge clk);
    check(cnt == 16'd7 && cnt_up == 1'b0, "R5 after peak", int'({cnt_up, cnt}), 7);

    // R10 holding copy commits at zero; direct write lands at once
    do_reset();
    write_reg(0, 16'd9);
    shadow_en = 1'b1; mode = 2'd0;
    do @(negedge clk); while (cnt != 16'd3);
    write_reg(0, 16'd19);
    max_until_wrap(mx);
    check(mx == 9, "R10 old period kept", mx, 9);
    max_until_wrap(mx);
    check(mx == 19, "R10/R3 new period", mx, 19);
    shadow_en = 1'b0;
    do @(negedge clk); while (cnt != 16'd2);
    write_reg(0, 16'd4);
    max_until_wrap(mx);
    check(mx == 4, "R10 direct write", mx, 4);

    // R11 hold freezes counter and outputs
    do_reset();
    write_reg(0, 16'd9);
    write_reg(1, 16'd4);
    act_word_a = 16'h0012;
    mode = 2'd0;
    repeat (13) @(negedge clk);
    mode = 2'd3;
    @(negedge clk);
    c0 = int'(cnt); a0 = pwm_a;
    repeat (20) @(negedge clk);
    check(int'(cnt) == c0, "R11 cnt frozen", int'(cnt), c0);
    check(pwm_a == a0, "R11 output frozen", int'(pwm_a), int'(a0));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule